// File: doc/BRIEF.md
# Four-Phase Clockless Bus Handshake Link

This block pairs an initiator controller and a responder controller that exchange single words without sharing a clock. The initiator runs on its own clock and the responder on another, unrelated one. The only timing coupling between the two sides is a request line, driven by the initiator, and an acknowledge line, driven by the responder. Each side passes the other side's line through a two-flop synchronizer before it acts on it.

A local client starts a transfer with a one-cycle start pulse. The initiator then places the address, the direction and, for a write, the data on the bus. It holds them for a parameterised number of initiator cycles so the target can decode them, and only then raises request. The responder answers in one of two ways. For a write, it stores the word in its small register file and raises acknowledge. For a read, it drives the stored word onto the data lines and raises acknowledge. When the initiator sees acknowledge, it drops request, capturing the read word at that point. The responder drops acknowledge once request is seen low, and releases the data lines one cycle later. The initiator reports completion only after it sees acknowledge low again. A new transfer can start from that point.

Top module: `async_hs_link`

## Requirements
- R1: After reset, request, acknowledge, the responder data drive, busy and done are all low, and every responder storage word reads back as zero.
- R2: Request rises exactly SETTLE_CYC initiator clock cycles after the cycle in which busy rises. SETTLE_CYC is at least 1 and defaults to 3.
- R3: A write (write flag 1) stores the data word at the addressed responder location. Later reads of that address return it, and the other addresses keep their contents.
- R4: A read (write flag 0) returns the word held at the addressed location on m_rdata_o. The value is valid in the cycle m_done_o is high.
- R5: While request is high and acknowledge has not yet been seen, the address, the direction and the master write data on the bus stay equal to the values accepted with the start pulse.
- R6: The handshake returns to zero in strict order: request rises only while acknowledge is low, acknowledge rises only while request is high, request falls only while acknowledge is high, and acknowledge falls only while request is low.
- R7: m_done_o pulses for one cycle only once acknowledge is low again. A start pulse that arrives while busy is ignored.
- R8: The responder drives the data lines only during a read, and it has stopped driving them by the cycle done is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_clk_i | input | 1 | Initiator clock |
| s_clk_i | input | 1 | Responder clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both sides |
| m_start_i | input | 1 | One-cycle transfer start (initiator domain) |
| m_write_i | input | 1 | 1 = write, 0 = read |
| m_addr_i | input | AW | Target word address |
| m_wdata_i | input | DW | Write word |
| m_busy_o | output | 1 | Transfer in progress |
| m_done_o | output | 1 | One-cycle completion pulse |
| m_rdata_o | output | DW | Last read word |
| bus_req_o | output | 1 | Request line |
| bus_ack_o | output | 1 | Acknowledge line |
| bus_addr_o | output | AW | Address lines |
| bus_write_o | output | 1 | Direction line |
| bus_data_o | output | DW | Resolved data lines |
| bus_sdrive_o | output | 1 | Responder is driving the data lines |

## Verification
A wrong settle counter shows at the ports at once, as a request edge arriving one or more initiator cycles early or late. A handshake state machine that skips a phase shows up within the same transfer, as an out-of-order edge on request or acknowledge, or as done arriving while acknowledge is still high. Bad storage or data capture stays hidden until the address is read back, so each write is followed by reads of the same address and of its neighbours. A responder that holds the data lines too long is visible at the done cycle of a read.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {M_IDLE, M_SETTLE, M_REQ, M_RTZ} mst_state_e;
  typedef enum logic [1:0] {S_IDLE, S_ACK, S_DROP} slv_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/hs_master.sv
module hs_master
  import hs_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int SETTLE_CYC = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  input  logic          ack_i,
  output logic          req_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_write_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_data_i
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  mst_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          ack_s, req_q, wr_q, done_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q, rd_q;

  hs_sync #(.STAGES(2)) u_ack_sync (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_i), .q_o(ack_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= M_IDLE;
      cnt_q   <= '0;
      req_q   <= 1'b0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      wd_q    <= '0;
      rd_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        M_IDLE: if (start_i && !ack_s) begin
          addr_q  <= addr_i;
          wr_q    <= write_i;
          wd_q    <= wdata_i;
          cnt_q   <= '0;
          state_q <= M_SETTLE;
        end
        M_SETTLE: if (cnt_q == CW'(SETTLE_CYC - 1)) begin
          req_q   <= 1'b1;
          state_q <= M_REQ;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        M_REQ: if (ack_s) begin
          req_q <= 1'b0;
          if (!wr_q) rd_q <= bus_data_i;
          state_q <= M_RTZ;
        end
        M_RTZ: if (!ack_s) begin
          done_q  <= 1'b1;
          state_q <= M_IDLE;
        end
        default: state_q <= M_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != M_IDLE);
  assign done_o      = done_q;
  assign rdata_o     = rd_q;
  assign req_o       = req_q;
  assign bus_addr_o  = addr_q;
  assign bus_write_o = wr_q;
  assign bus_wdata_o = (busy_o && wr_q) ? wd_q : '0;

  // R5: bus fields frozen while waiting for acknowledge
  p_bus_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_s) |=> ($stable(addr_q) && $stable(wr_q) && $stable(wd_q)));
  // R6: request drops only after acknowledge has been seen
  p_req_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_q) |-> $past(ack_s));
  // R7: no new transfer while acknowledge still high
  p_accept_ack_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !$past(ack_s));
  // R7: completion only with acknowledge low
  p_done_ack_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!req_q && !$past(ack_s)));
endmodule

// File: rtl/hs_slave.sv
module hs_slave
  import hs_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          write_i,
  input  logic [DW-1:0] data_i,
  output logic          ack_o,
  output logic          drive_o,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  slv_state_e    state_q;
  logic          req_s, ack_q, drv_q;
  logic [DW-1:0] rd_q;
  logic [DW-1:0] mem_q [DEPTH];

  hs_sync #(.STAGES(2)) u_req_sync (.clk_i(clk_i), .rst_ni(rst_ni), .d_i(req_i), .q_o(req_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ack_q   <= 1'b0;
      drv_q   <= 1'b0;
      rd_q    <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req_s) begin
          if (write_i) begin
            mem_q[addr_i] <= data_i;
          end else begin
            rd_q  <= mem_q[addr_i];
            drv_q <= 1'b1;
          end
          ack_q   <= 1'b1;
          state_q <= S_ACK;
        end
        S_ACK: if (!req_s) begin
          ack_q   <= 1'b0;
          state_q <= drv_q ? S_DROP : S_IDLE;
        end
        S_DROP: begin
          drv_q   <= 1'b0;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign ack_o   = ack_q;
  assign drive_o = drv_q;
  assign rdata_o = rd_q;

  // R6: acknowledge rises only on a seen request, falls only once it is gone
  p_ack_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> $past(req_s));
  p_ack_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_q) |-> !$past(req_s));
  // R8: data lines released only after acknowledge is low
  p_drive_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drv_q) |-> !ack_q);
  // R8: driving starts together with acknowledge
  p_drive_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_q) |-> $rose(ack_q));
endmodule

// File: rtl/async_hs_link.sv
module async_hs_link #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int SETTLE_CYC = 3
) (
  input  logic          m_clk_i,
  input  logic          s_clk_i,
  input  logic          rst_ni,
  input  logic          m_start_i,
  input  logic          m_write_i,
  input  logic [AW-1:0] m_addr_i,
  input  logic [DW-1:0] m_wdata_i,
  output logic          m_busy_o,
  output logic          m_done_o,
  output logic [DW-1:0] m_rdata_o,
  output logic          bus_req_o,
  output logic          bus_ack_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_write_o,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_sdrive_o
);
  logic          req, ack, wr, sdrv;
  logic [AW-1:0] addr;
  logic [DW-1:0] mdata, sdata, bdata;

  hs_master #(.AW(AW), .DW(DW), .SETTLE_CYC(SETTLE_CYC)) u_mst (
    .clk_i(m_clk_i), .rst_ni(rst_ni),
    .start_i(m_start_i), .write_i(m_write_i), .addr_i(m_addr_i), .wdata_i(m_wdata_i),
    .busy_o(m_busy_o), .done_o(m_done_o), .rdata_o(m_rdata_o),
    .ack_i(ack), .req_o(req), .bus_addr_o(addr), .bus_write_o(wr),
    .bus_wdata_o(mdata), .bus_data_i(bdata)
  );

  hs_slave #(.AW(AW), .DW(DW)) u_slv (
    .clk_i(s_clk_i), .rst_ni(rst_ni),
    .req_i(req), .addr_i(addr), .write_i(wr), .data_i(bdata),
    .ack_o(ack), .drive_o(sdrv), .rdata_o(sdata)
  );

  // shared data lines resolved as a mux: responder wins while it drives
  assign bdata = sdrv ? sdata : mdata;

  assign bus_req_o    = req;
  assign bus_ack_o    = ack;
  assign bus_addr_o   = addr;
  assign bus_write_o  = wr;
  assign bus_data_o   = bdata;
  assign bus_sdrive_o = sdrv;
endmodule

// File: tb/async_hs_link_bench.sv
`timescale 1ns/1ps
module async_hs_link_bench;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int SETTLE = 3;

  logic m_clk = 1'b0, s_clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic m_busy, m_done, b_req, b_ack, b_write, b_sdrive;
  logic [DW-1:0] m_rdata, b_data;
  logic [AW-1:0] b_addr;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #2.5 m_clk = ~m_clk;
  initial begin
    #1.1;
    forever #3.65 s_clk = ~s_clk;
  end

  async_hs_link #(.AW(AW), .DW(DW), .SETTLE_CYC(SETTLE)) u_async_hs_link (
    .m_clk_i(m_clk), .s_clk_i(s_clk), .rst_ni(rst_n),
    .m_start_i(start), .m_write_i(wr), .m_addr_i(addr), .m_wdata_i(wdata),
    .m_busy_o(m_busy), .m_done_o(m_done), .m_rdata_o(m_rdata),
    .bus_req_o(b_req), .bus_ack_o(b_ack), .bus_addr_o(b_addr), .bus_write_o(b_write),
    .bus_data_o(b_data), .bus_sdrive_o(b_sdrive)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // R6: return-to-zero ordering watched on every handshake edge
  always @(posedge b_req) if (rst_n) chk(b_ack == 1'b0, "R6 req rise with ack low", b_ack, 0);
  always @(negedge b_req) if (rst_n) chk(b_ack == 1'b1, "R6 req fall with ack high", b_ack, 1);
  always @(posedge b_ack) if (rst_n) chk(b_req == 1'b1, "R6 ack rise with req high", b_req, 1);
  always @(negedge b_ack) if (rst_n) chk(b_req == 1'b0, "R6 ack fall with req low", b_req, 0);

  initial begin
    repeat (100000) @(posedge m_clk);
    fails++;
    $display("FAIL watchdog: actual=hang expected=completion");
    finish_run();
  end

  task automatic xfer(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input bit poke, output logic [DW-1:0] rd);
    int cnt;
    int guard;
    bit saw_drive;
    @(negedge m_clk);
    start = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge m_clk);
    start = 1'b0;
    cnt = 0;
    while (!b_req && cnt < 100) begin
      cnt++;
      if (poke && cnt == 1) begin
        start = 1'b1; wr = 1'b1; addr = ~a; wdata = ~d;
      end else begin
        start = 1'b0;
      end
      @(negedge m_clk);
    end
    start = 1'b0;
    chk(cnt == SETTLE, "R2 settle cycles before req", cnt, SETTLE);
    chk(b_addr == a, "R5 address at req", b_addr, a);
    chk(b_write == w, "R5 direction at req", b_write, w);
    if (w) chk(b_data == d, "R5 write data at req", b_data, d);
    saw_drive = 1'b0;
    guard = 0;
    while (!m_done && guard < 1000) begin
      if (b_sdrive) saw_drive = 1'b1;
      if (b_req && !b_ack) begin
        if (b_addr != a || b_write != w || (w && b_data != d))
          chk(1'b0, "R5 bus held during req", b_addr, a);
      end
      guard++;
      @(negedge m_clk);
    end
    chk(m_done, "R7 done reported", m_done, 1);
    chk(b_ack == 1'b0, "R7 ack low at done", b_ack, 0);
    chk(b_sdrive == 1'b0, "R8 data lines released by done", b_sdrive, 0);
    chk(saw_drive == !w, "R8 responder drives only on read", saw_drive, !w);
    rd = m_rdata;
    @(negedge m_clk);
    chk(m_done == 1'b0, "R7 done is one cycle", m_done, 0);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] unused;
    xfer(1'b1, a, d, 1'b0, unused);
  endtask

  task automatic do_read_check(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    logic [DW-1:0] got;
    xfer(1'b0, a, '0, 1'b0, got);
    chk(got == exp, tag, got, exp);
  endtask

  task automatic test_reset();
    repeat (4) @(negedge m_clk);
    chk(!b_req && !b_ack, "R1 handshake low in reset", {b_req, b_ack}, 0);
    chk(!m_busy && !m_done && !b_sdrive, "R1 status low in reset", {m_busy, m_done, b_sdrive}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge m_clk);
    chk(!b_req && !b_ack && !m_busy, "R1 idle after reset", {b_req, b_ack, m_busy}, 0);
  endtask

  task automatic test_fresh_reads();
    do_read_check(4'h0, '0, "R1 storage zero after reset addr0");
    do_read_check(4'hF, '0, "R1 storage zero after reset addrF");
  endtask

  task automatic test_write_read();
    do_write(4'h3, 16'hA5C3);
    do_write(4'h4, 16'hFFFF);
    do_write(4'hC, 16'h5555);
    do_read_check(4'h3, 16'hA5C3, "R4 read addr3");
    do_read_check(4'h4, 16'hFFFF, "R4 read addr4 all ones");
    do_read_check(4'hC, 16'h5555, "R4 read addrC alternating");
    do_read_check(4'h2, '0, "R3 neighbour addr2 untouched");
  endtask

  task automatic test_overwrite();
    do_write(4'h3, 16'h0000);
    do_read_check(4'h3, 16'h0000, "R3 overwrite to zero");
    do_read_check(4'h4, 16'hFFFF, "R3 other word kept");
  endtask

  task automatic test_start_while_busy();
    logic [DW-1:0] unused;
    // poke writes ~addr with ~data during settle; must be ignored
    xfer(1'b1, 4'h1, 16'h1234, 1'b1, unused);
    do_read_check(4'h1, 16'h1234, "R3 poked transfer completes");
    do_read_check(4'hE, '0, "R7 start while busy ignored");
  endtask

  task automatic test_back_to_back();
    for (int i = 0; i < 6; i++) do_write(AW'(i + 6), DW'(16'h1111 * (i + 1)));
    for (int i = 0; i < 6; i++)
      do_read_check(AW'(i + 6), DW'(16'h1111 * (i + 1)), "R4 back to back readback");
  endtask

  initial begin
    test_reset();
    test_fresh_reads();
    test_write_read();
    test_overwrite();
    test_start_while_busy();
    test_back_to_back();
    repeat (10) @(negedge m_clk);
    finish_run();
  end
endmodule